// File: doc/BRIEF.md
# Serial Converter Device-Side Front End

This block is the digital side of an 8-bit serial sampling converter that has a 12-way input selector. A host lowers chip select and clocks eight SCLK periods. During those periods the block takes in a 4-bit selector code on DI and returns the previous conversion result on DO, most significant bit first. The eighth falling SCLK edge freezes the selected input value and starts a conversion. The conversion runs for a fixed, parameterised number of conversion-clock cycles. The analog path is abstract: the selector code appears on `chan_sel`, and the environment supplies the matching 8-bit code on `ana_code`. The block samples `ana_code` when the conversion starts.

All internal state runs on the free-running conversion clock. SCLK, DI and chip select are asynchronous to that clock, so each is resynchronised. Chip select is also deglitched, and its filtered level controls the sequencer. The DO output enable is the exception: it follows the raw chip-select pin, so the first result bit is visible as soon as chip select falls. A chip-select strobe that outlasts the filter aborts a transfer or a conversion. A result-valid flag shows whether the stored result came from a complete conversion.

Top module: `sadc_front_end`

## Requirements
- R1: The first four SCLK rising edges of a transfer shift DI into the selector code, MSB first, and the code appears on `chan_sel`. Further rising edges in the same transfer leave `chan_sel` unchanged.
- R2: While `cs_n` is low, `do_oe` is 1. While `cs_n` is high, `do_oe` is 0. At the moment `cs_n` falls, `do_data` already shows bit 7 of the stored result. Falling SCLK edges 1 to 7 then present bits 6 down to 0.
- R3: Codes 0 to 10 convert the `ana_code` value. Code 11 converts the fixed half-scale value 0x80. `test_mode` is 1 exactly when `chan_sel` holds 12 to 15.
- R4: The eighth falling SCLK edge starts a conversion. `busy` then stays high for exactly CONV_CYCLES cycles, where CONV_CYCLES lies between 48 and 64.
- R5: A `cs_n` pulse shorter than one clock period never aborts anything or starts an exchange. A change takes effect only after two synchroniser stages and CS_FILT_LEN equal consecutive samples.
- R6: If `cs_n` goes high for longer than the filter time during a transfer, the block returns to idle without converting and clears `result_valid`. The next exchange shifts out the stored result unchanged.
- R7: If `cs_n` falls after a filtered high during a conversion, the conversion ends at once. `busy` drops, `result_valid` clears, the stored result is kept, and a new exchange begins.
- R8: If `cs_n` stays low through a conversion, `do_data` is 0 until the conversion ends. It then shows bit 7 of the new result, and the next exchange runs without any `cs_n` toggle.
- R9: If `cs_n` is high during a conversion, the conversion completes normally and SCLK/DI activity is ignored: `chan_sel` is unchanged.
- R10: `result_valid` is 0 after reset, is set at the end of every complete conversion, and is cleared by any abort.
- R11: After reset `busy`, `result_valid` and `test_mode` are 0 and the stored result is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running conversion clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous, much slower than clk |
| di | input | 1 | Serial selector-code input |
| ana_code | input | DATA_W | Behavioural converted value of the selected input |
| do_data | output | 1 | Serial result bit |
| do_oe | output | 1 | Drive enable for the serial output (0 = high impedance) |
| chan_sel | output | ADDR_W | Selector code currently applied |
| test_mode | output | 1 | Reserved digital-test code selected |
| busy | output | 1 | Conversion in progress |
| result_valid | output | 1 | Stored result came from a complete conversion |

## Verification
A chip-select change is acted on at the fourth rising clock edge after it: two synchroniser stages, then two filter samples. `do_oe` follows the pin within the same time step, so the bench checks it and the first data bit one nanosecond after lowering `cs_n`. An SCLK edge takes effect at the third clock edge after the pin moves. The bench therefore holds every SCLK phase for eight clock cycles and samples DO only at the end of the low phase, at a falling clock edge. A monitor counts `busy` cycles on two instances, built with 64 and 48 cycles, so the conversion length is checked exactly at both limits.

// File: rtl/sadc_pkg.sv
// Shared definitions for the serial converter front end.
// Assumes a 4-bit selector code space (codes 11 and 12..15 are reserved).
package sadc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_CONV = 2'd2
    } sadc_state_e;

    localparam int TEST_SRC_CODE  = 11;  // internal half-scale source
    localparam int TEST_MODE_BASE = 12;  // first reserved digital-test code

endpackage

// File: rtl/sadc_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes STAGES >= 2; all bits of d are independent or quasi-static together.
module sadc_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    // Shift the raw inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/sadc_cs_filter.sv
// Chip-select conditioner: synchronizes cs_n, then accepts a new level only
// after FILT_LEN consecutive equal samples. Emits a one-cycle pulse after an
// accepted falling transition. Assumes FILT_LEN >= 2 so one-sample spikes die.
module sadc_cs_filter #(
    parameter int STAGES   = 2,
    parameter int FILT_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_raw,
    output logic cs_q,
    output logic cs_fell
);

    localparam int              CW   = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0]   LAST = CW'(FILT_LEN - 1);

    logic          cs_s;
    logic [CW-1:0] cnt;

    sadc_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cs_n_raw),
        .q     (cs_s)
    );

    // Count consecutive disagreeing samples; adopt the level once stable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q    <= 1'b1;
            cnt     <= '0;
            cs_fell <= 1'b0;
        end else begin
            cs_fell <= 1'b0;
            if (cs_s == cs_q) begin
                cnt <= '0;
            end else if (cnt == LAST) begin
                cs_q    <= cs_s;
                cnt     <= '0;
                cs_fell <= ~cs_s;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R5: the filtered level only ever takes the value the synchronizer held
    a_r5_filter_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cs_q) |-> (cs_q == $past(cs_s)));

endmodule

// File: rtl/sadc_edge_sync.sv
// Serial-clock front end: resynchronizes SCLK together with DI and reports
// single-cycle rising and falling edge events. Assumes SCLK phases last well
// over STAGES+1 conversion-clock periods.
module sadc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_raw,
    input  logic di_raw,
    output logic rise,
    output logic fall,
    output logic di_q
);

    logic [1:0] pair_s;
    logic       sclk_prev;

    sadc_sync #(.W(2), .STAGES(STAGES), .RST_VAL(2'b00)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk_raw, di_raw}),
        .q     (pair_s)
    );

    // Remember the previous synchronized SCLK level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
        end else begin
            sclk_prev <= pair_s[1];
        end
    end

    assign rise = pair_s[1] & ~sclk_prev;
    assign fall = ~pair_s[1] & sclk_prev;
    assign di_q = pair_s[0];

endmodule

// File: rtl/sadc_conv_timer.sv
// Conversion duration counter: while run is high it counts cycles and pulses
// done on the CYCLES-th cycle, then rearms. Dropping run clears it.
module sadc_conv_timer #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int            CW   = $clog2(CYCLES);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    assign done = run && (cnt == LAST);

    // Advance during a conversion, restart on completion or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (run && !done) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end

endmodule

// File: rtl/sadc_front_end.sv
// Device-side digital front end of a serial 8-bit converter with a 12-way
// selector. Runs entirely on the conversion clock; SCLK, DI and chip select
// are resynchronized, chip select is deglitched. DO enable follows the raw
// pin. Assumes SCLK is far slower than clk and ADDR_W >= 3.
module sadc_front_end
    import sadc_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 4,
    parameter int CONV_CYCLES = 64,
    parameter int SYNC_STAGES = 2,
    parameter int CS_FILT_LEN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              di,
    input  logic [DATA_W-1:0] ana_code,
    output logic              do_data,
    output logic              do_oe,
    output logic [ADDR_W-1:0] chan_sel,
    output logic              test_mode,
    output logic              busy,
    output logic              result_valid
);

    localparam int                RC_W      = $clog2(ADDR_W + 1);
    localparam int                FC_W      = $clog2(DATA_W + 1);
    localparam logic [RC_W-1:0]   RC_FULL   = RC_W'(ADDR_W);
    localparam logic [RC_W-1:0]   RC_LAST   = RC_W'(ADDR_W - 1);
    localparam logic [FC_W-1:0]   FC_LAST   = FC_W'(DATA_W - 1);
    localparam logic [ADDR_W-1:0] SRC_HALF  = ADDR_W'(TEST_SRC_CODE);
    localparam logic [ADDR_W-1:0] SRC_DIG   = ADDR_W'(TEST_MODE_BASE);
    localparam logic [DATA_W-1:0] HALF_CODE = {1'b1, {(DATA_W-1){1'b0}}};

    sadc_state_e       state;
    logic              cs_q;
    logic              cs_fell;
    logic              sck_rise;
    logic              sck_fall;
    logic              di_q;
    logic              in_conv;
    logic              conv_done;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] result;
    logic [DATA_W-1:0] sample;
    logic [ADDR_W-2:0] addr_sh;
    logic [ADDR_W-1:0] chan;
    logic [RC_W-1:0]   rise_cnt;
    logic [FC_W-1:0]   fall_cnt;
    logic              valid;

    sadc_cs_filter #(.STAGES(SYNC_STAGES), .FILT_LEN(CS_FILT_LEN)) u_cs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_raw (cs_n),
        .cs_q     (cs_q),
        .cs_fell  (cs_fell)
    );

    sadc_edge_sync #(.STAGES(SYNC_STAGES)) u_sck (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_raw (sclk),
        .di_raw   (di),
        .rise     (sck_rise),
        .fall     (sck_fall),
        .di_q     (di_q)
    );

    sadc_conv_timer #(.CYCLES(CONV_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_conv),
        .done  (conv_done)
    );

    assign in_conv = (state == ST_CONV);

    // Exchange / conversion sequencer with abort handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            result   <= '0;
            sample   <= '0;
            addr_sh  <= '0;
            chan     <= '0;
            rise_cnt <= '0;
            fall_cnt <= '0;
            valid    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (!cs_q) begin
                        state    <= ST_XFER;
                        rise_cnt <= '0;
                        fall_cnt <= '0;
                    end
                end
                ST_XFER: begin
                    if (cs_q) begin
                        state <= ST_IDLE;
                        valid <= 1'b0;
                        shreg <= result;
                    end else if (sck_rise && rise_cnt != RC_FULL) begin
                        addr_sh  <= {addr_sh[ADDR_W-3:0], di_q};
                        rise_cnt <= rise_cnt + 1'b1;
                        if (rise_cnt == RC_LAST) begin
                            chan <= {addr_sh, di_q};
                        end
                    end else if (sck_fall && rise_cnt != '0) begin
                        if (fall_cnt == FC_LAST) begin
                            state  <= ST_CONV;
                            sample <= (chan == SRC_HALF) ? HALF_CODE : ana_code;
                        end else begin
                            shreg <= {shreg[DATA_W-2:0], 1'b0};
                        end
                        fall_cnt <= fall_cnt + 1'b1;
                    end
                end
                ST_CONV: begin
                    if (cs_fell) begin
                        state    <= ST_XFER;
                        valid    <= 1'b0;
                        shreg    <= result;
                        rise_cnt <= '0;
                        fall_cnt <= '0;
                    end else if (conv_done) begin
                        result   <= sample;
                        shreg    <= sample;
                        valid    <= 1'b1;
                        rise_cnt <= '0;
                        fall_cnt <= '0;
                        state    <= cs_q ? ST_IDLE : ST_XFER;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign do_oe        = ~cs_n;
    assign do_data      = in_conv ? 1'b0 : shreg[DATA_W-1];
    assign chan_sel     = chan;
    assign test_mode    = (chan >= SRC_DIG);
    assign busy         = in_conv;
    assign result_valid = valid;

    // R2: within a transfer the output register moves only on a SCLK fall
    a_r2_shift_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && $past(state) == ST_XFER && !$past(sck_fall))
            |-> $stable(shreg));

    // R4: a conversion begins only on a detected SCLK falling edge
    a_r4_start_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_conv) |-> $past(sck_fall));

    // R7: a conversion ends only by timer completion or a filtered CS fall
    a_r7_busy_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_conv) |-> ($past(conv_done) || $past(cs_fell)));

    // R10: the valid flag is raised only from inside a conversion
    a_r10_valid_from_conv: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> $past(in_conv));

endmodule

// File: tb/sadc_front_end_test.sv
module sadc_front_end_test;

    localparam int HALF = 8;  // clk cycles per SCLK phase

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cs_n;
    logic       sclk;
    logic       di;
    logic [7:0] ana_code;

    logic       do_data, do_oe, test_mode, busy, result_valid;
    logic [3:0] chan_sel;
    logic       do_b, oe_b, tm_b, busy_b, val_b;
    logic [3:0] chan_b;

    int checks = 0;
    int errors = 0;
    int run_a = 0, len_a = 0, run_b = 0, len_b = 0;

    always #5 clk = ~clk;

    sadc_front_end #(.CONV_CYCLES(64)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .di(di),
        .ana_code(ana_code), .do_data(do_data), .do_oe(do_oe),
        .chan_sel(chan_sel), .test_mode(test_mode), .busy(busy),
        .result_valid(result_valid)
    );

    sadc_front_end #(.CONV_CYCLES(48)) uut48 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .di(di),
        .ana_code(ana_code), .do_data(do_b), .do_oe(oe_b),
        .chan_sel(chan_b), .test_mode(tm_b), .busy(busy_b),
        .result_valid(val_b)
    );

    // Measure the length of each busy interval on both instances.
    always @(negedge clk) begin
        if (busy) run_a++;
        else if (run_a != 0) begin len_a = run_a; run_a = 0; end
        if (busy_b) run_b++;
        else if (run_b != 0) begin len_b = run_b; run_b = 0; end
    end

    // {code, ana_code} stimulus vectors
    localparam logic [11:0] VEC [6] = '{
        {4'd3,  8'hA5},
        {4'd11, 8'h3C},
        {4'd0,  8'hFF},
        {4'd10, 8'h01},
        {4'd13, 8'h5A},
        {4'd7,  8'h00}
    };

    function automatic logic [7:0] expect_code(input logic [3:0] code, input logic [7:0] v);
        return (code == 4'd11) ? 8'h80 : v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_low(input logic exp_msb);
        @(negedge clk);
        cs_n = 1'b0;
        #1;
        chk("R2 oe at cs fall", {31'd0, do_oe}, 32'd1);
        chk("R2 msb at cs fall", {31'd0, do_data}, {31'd0, exp_msb});
        tick(6);
    endtask

    task automatic sclk_cycle(input logic d);
        di = d;
        tick(HALF);
        sclk = 1'b1;
        tick(HALF);
        sclk = 1'b0;
        tick(HALF);
    endtask

    task automatic shift_byte(input logic [3:0] code, input logic glitch, output logic [7:0] got);
        got[7] = do_data;
        for (int i = 0; i < 8; i++) begin
            sclk_cycle((i < 4) ? code[3-i] : 1'b0);
            if (i < 7) got[6-i] = do_data;
            if (glitch && i == 3) begin
                #3 cs_n = 1'b1;
                #5 cs_n = 1'b0;
            end
        end
    endtask

    initial begin
        logic [7:0] prev;
        logic [7:0] got;
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; di = 1'b0; ana_code = 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(2);
        // R11 reset state
        chk("R11 busy", {31'd0, busy}, 32'd0);
        chk("R11 valid", {31'd0, result_valid}, 32'd0);
        chk("R11 test_mode", {31'd0, test_mode}, 32'd0);
        chk("R2 oe off cs high", {31'd0, do_oe}, 32'd0);
        prev = 8'h00;

        // Table walk: R1 R2 R3 R4 R10
        for (int k = 0; k < 6; k++) begin
            logic [3:0] code;
            code = VEC[k][11:8];
            ana_code = VEC[k][7:0];
            cs_low(prev[7]);
            shift_byte(code, 1'b0, got);
            chk("R2 byte out", {24'd0, got}, {24'd0, prev});
            chk("R1 chan_sel", {28'd0, chan_sel}, {28'd0, code});
            chk("R3 test_mode", {31'd0, test_mode}, {31'd0, (code >= 4'd12)});
            @(negedge clk);
            cs_n = 1'b1;
            #1;
            chk("R2 oe off", {31'd0, do_oe}, 32'd0);
            tick(80);
            chk("R10 valid set", {31'd0, result_valid}, 32'd1);
            chk("R4 busy len 64", len_a, 32'd64);
            chk("R4 busy len 48", len_b, 32'd48);
            prev = expect_code(code, VEC[k][7:0]);
        end

        // R8: cs held low through conversion, automatic next exchange
        ana_code = 8'hC3;
        cs_low(prev[7]);
        shift_byte(4'd2, 1'b0, got);
        chk("R8 byte out", {24'd0, got}, {24'd0, prev});
        chk("R8 busy during", {31'd0, busy}, 32'd1);
        chk("R8 oe during", {31'd0, do_oe}, 32'd1);
        chk("R8 do low during", {31'd0, do_data}, 32'd0);
        tick(70);
        chk("R8 conv done", {31'd0, busy}, 32'd0);
        chk("R8 new msb", {31'd0, do_data}, 32'd1);
        ana_code = 8'h3C;
        shift_byte(4'd5, 1'b0, got);
        chk("R8 next exchange", {24'd0, got}, 32'hC3);
        @(negedge clk);
        cs_n = 1'b1;
        tick(80);
        prev = 8'h3C;

        // R9: cs high during conversion, SCLK/DI ignored
        ana_code = 8'h96;
        cs_low(prev[7]);
        shift_byte(4'd1, 1'b0, got);
        chk("R9 byte out", {24'd0, got}, {24'd0, prev});
        @(negedge clk);
        cs_n = 1'b1;
        for (int j = 0; j < 8; j++) begin
            sclk_cycle(1'b1);
            if (j == 1) chk("R9 oe off in conv", {31'd0, do_oe}, 32'd0);
        end
        chk("R9 chan unchanged", {28'd0, chan_sel}, 32'd1);
        chk("R9 valid", {31'd0, result_valid}, 32'd1);
        chk("R9 busy done", {31'd0, busy}, 32'd0);
        prev = 8'h96;

        // R5: sub-period glitch on cs_n mid-transfer is ignored
        ana_code = 8'h44;
        cs_low(prev[7]);
        shift_byte(4'd6, 1'b1, got);
        chk("R5 byte out", {24'd0, got}, {24'd0, prev});
        chk("R5 conversion started", {31'd0, busy}, 32'd1);
        @(negedge clk);
        cs_n = 1'b1;
        tick(80);
        chk("R5 valid", {31'd0, result_valid}, 32'd1);
        prev = 8'h44;

        // R6: abort during transfer
        cs_low(prev[7]);
        sclk_cycle(1'b1);
        sclk_cycle(1'b0);
        sclk_cycle(1'b1);
        @(negedge clk);
        cs_n = 1'b1;
        tick(10);
        chk("R6 valid cleared", {31'd0, result_valid}, 32'd0);
        chk("R6 no conversion", {31'd0, busy}, 32'd0);
        ana_code = 8'h21;
        cs_low(prev[7]);
        shift_byte(4'd4, 1'b0, got);
        chk("R6 result kept", {24'd0, got}, {24'd0, prev});
        @(negedge clk);
        cs_n = 1'b1;
        tick(80);
        chk("R10 valid after redo", {31'd0, result_valid}, 32'd1);
        prev = 8'h21;

        // R7: abort during conversion by a high-then-low strobe
        ana_code = 8'h77;
        cs_low(prev[7]);
        shift_byte(4'd9, 1'b0, got);
        chk("R7 byte out", {24'd0, got}, {24'd0, prev});
        @(negedge clk);
        cs_n = 1'b1;
        tick(6);
        cs_n = 1'b0;
        tick(8);
        chk("R7 busy dropped", {31'd0, busy}, 32'd0);
        chk("R7 valid cleared", {31'd0, result_valid}, 32'd0);
        ana_code = 8'h12;
        shift_byte(4'd8, 1'b0, got);
        chk("R7 result kept", {24'd0, got}, {24'd0, prev});
        @(negedge clk);
        cs_n = 1'b1;
        tick(80);
        chk("R10 valid again", {31'd0, result_valid}, 32'd1);
        cs_low(1'b0);
        shift_byte(4'd0, 1'b0, got);
        chk("R7 later result", {24'd0, got}, 32'h12);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule